// File: doc/BRIEF.md
# First-Order Sigma-Delta Bit DAC

This block turns a 14-bit unsigned sample into a single-bit pulse-density stream. On each clock it adds the sample to a 16-bit accumulator. When the current output bit is high it also subtracts one full-scale step of 2^14 from that accumulator. The accumulator's top bit passes through one more flip-flop and drives the output pin. The average density of ones therefore tracks the input value divided by 2^14. An external low-pass filter, which is not part of this block, recovers the analog level.

The loop updates once per clock and keeps no other state. A designer drives `sample_in` from any synchronous source. The loop noise-shapes the quantization error. It does so for slowly changing inputs and for inputs that change on every clock.

Top module: `sdm_bit_dac`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator and `bit_out` are cleared to zero. The first output after reset is released is 0.
- R2: The step added to the accumulator is `sample_in` zero-extended to 16 bits, plus a feedback word. The feedback word holds the current `bit_out` value in bits 15 and 14 and zeros in bits 13..0. So the step is `sample_in` when `bit_out` is 0, and `sample_in` − 16384 (mod 2^16) when `bit_out` is 1.
- R3: The accumulator is loaded with its previous value plus the R2 step on every clock where reset is low.
- R4: `bit_out` equals accumulator bit 15 as it was one clock earlier.
- R5: For any input sequence the accumulator never wraps. It does not decrease while `bit_out` is 0, and it does not increase while `bit_out` is 1.
- R6: With a constant input N held from reset, consider the first 2^14 output samples after reset is released. The number of ones among them is N−k for some k in 0..3.
- R7: With input 0 held from reset, `bit_out` stays 0 on every clock.
- R8: With input 16383 held from reset, count over the 2^15 clocks that follow the first 8 clocks. `bit_out` is 0 on at most 2 of those clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 14 | Unsigned input sample |
| bit_out | output | 1 | Registered pulse-density output |

## Verification
The assertions assume that `sample_in` is a settled unsigned 14-bit value at every rising edge. They also assume that reset has been applied at least once before any check is armed. No further constraint applies, because every 14-bit value is a legal input on every clock.

The bench drives a new input only at falling edges, so this assumption holds. It holds `rst` high from time zero. Its random values span the full 0..16383 range, and its directed runs reach both range ends.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    // default input word width; the accumulator carries two guard bits above it
    parameter int unsigned SDM_DATA_W  = 14;
    parameter int unsigned SDM_GUARD_W = 2;
endpackage

// File: rtl/sdm_delta_adder.sv
module sdm_delta_adder #(
    parameter int unsigned DW = sdm_pkg::SDM_DATA_W,
    parameter int unsigned GW = sdm_pkg::SDM_GUARD_W
) (
    input  logic [DW-1:0]    sample,
    input  logic             fb_bit,
    output logic [DW+GW-1:0] step
);
    localparam int unsigned AW = DW + GW;

    logic [AW-1:0] sample_ext;
    logic [AW-1:0] fb_word;

    // feedback word: output bit replicated over the guard bits, zeros below
    always_comb begin
        sample_ext = {{GW{1'b0}}, sample};
        fb_word    = {{GW{fb_bit}}, {DW{1'b0}}};
        step       = sample_ext + fb_word;
    end
endmodule

// File: rtl/sdm_sigma_accum.sv
module sdm_sigma_accum #(
    parameter int unsigned AW = sdm_pkg::SDM_DATA_W + sdm_pkg::SDM_GUARD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc + step;
    end
endmodule

// File: rtl/sdm_out_reg.sv
module sdm_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/sdm_bit_dac.sv
module sdm_bit_dac #(
    parameter int unsigned DW = sdm_pkg::SDM_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] sample_in,
    output logic          bit_out
);
    localparam int unsigned GW = sdm_pkg::SDM_GUARD_W;
    localparam int unsigned AW = DW + GW;

    logic [AW-1:0] step_w;
    logic [AW-1:0] acc_q;

    sdm_delta_adder #(.DW(DW), .GW(GW)) u_delta (
        .sample (sample_in),
        .fb_bit (bit_out),
        .step   (step_w)
    );

    sdm_sigma_accum #(.AW(AW)) u_sigma (
        .clk  (clk),
        .rst  (rst),
        .step (step_w),
        .acc  (acc_q)
    );

    sdm_out_reg u_out (
        .clk (clk),
        .rst (rst),
        .d   (acc_q[AW-1]),
        .q   (bit_out)
    );
endmodule

// File: rtl/sdm_bit_dac_chk.sv
module sdm_bit_dac_chk #(
    parameter int unsigned DW = sdm_pkg::SDM_DATA_W,
    parameter int unsigned AW = DW + sdm_pkg::SDM_GUARD_W
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] sample_in,
    input logic [AW-1:0] acc,
    input logic          bit_out
);
    localparam logic [AW-1:0] FULL_STEP = AW'(1) << DW;

    logic [AW-1:0] next_expect;
    always_comb begin
        next_expect = acc + AW'(sample_in);
        if (bit_out) next_expect = next_expect - FULL_STEP;
    end

    // R1: reset leaves both state elements at zero
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc == '0 && bit_out == 1'b0));

    // R2, R3: accumulator advances by the feedback-adjusted input each clock
    a_r3_accumulate: assert property (@(posedge clk) disable iff (rst)
        !rst |=> acc == $past(next_expect));

    // R4: output is the accumulator MSB delayed one clock
    a_r4_out_lag: assert property (@(posedge clk) disable iff (rst)
        !rst |=> bit_out == $past(acc[AW-1]));

    // R5: no wrap while rising
    a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (!rst && !bit_out) |=> acc >= $past(acc));

    // R5: no wrap while falling
    a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (!rst && bit_out) |=> acc <= $past(acc));
endmodule

bind sdm_bit_dac sdm_bit_dac_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .acc       (acc_q),
    .bit_out   (bit_out)
);

// File: tb/sdm_bit_dac_test.sv
module sdm_bit_dac_test;
    localparam int DW = 14;
    localparam int FS = 1 << DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          bit_out;

    int checks = 0;
    int failures = 0;
    int m_acc = 0;
    int m_out = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdm_bit_dac #(.DW(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .bit_out   (bit_out)
    );

    // reference step from R2/R3/R4: returns next model state
    function automatic int model_acc(input int acc, input int din, input int outb);
        return (acc + din + (outb != 0 ? 4 * FS - FS : 0)) % (4 * FS);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(bit_out == 1'b0, "R1 reset output", int'(bit_out), 0);
        rst = 1'b0;
        m_acc = 0;
        m_out = 0;
    endtask

    // apply value at a falling edge, advance model by one clock
    task automatic step_model(input int din);
        int old_acc;
        sample_in = DW'(din);
        old_acc = m_acc;
        m_acc = model_acc(m_acc, din, m_out);
        m_out = (old_acc >> (DW + 1)) & 1;
        @(negedge clk);
    endtask

    task automatic density_run(input int n);
        int ones = 0;
        do_reset();
        sample_in = DW'(n);
        for (int i = 0; i < FS; i++) begin
            if (bit_out) ones++;
            @(negedge clk);
        end
        check(ones <= n && ones >= n - 3, "R6 density", ones, n);
    endtask

    initial begin
        int mism;
        int zeros;
        void'($urandom(32'd20240611));

        // R1 and R3/R4 per-cycle against the reference under random input
        do_reset();
        check(bit_out == 1'b0, "R1 first output after reset", int'(bit_out), 0);
        for (int i = 0; i < 4000; i++) begin
            int din;
            int r = int'($urandom % 8);
            if (r == 0)      din = 0;
            else if (r == 1) din = FS - 1;
            else             din = int'($urandom % FS);
            step_model(din);
            check(int'(bit_out) == m_out, "R2 R3 R4 random stream", int'(bit_out), m_out);
        end

        // R5 slow ramp and alternating extremes against the reference
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            int din = (i % 2 == 0) ? FS - 1 : 0;
            if (i >= 1000) din = (i * 17) % FS;
            step_model(din);
            check(int'(bit_out) == m_out, "R5 extremes and ramp", int'(bit_out), m_out);
        end

        // R6 constant-input densities
        density_run(1);
        density_run(5000);
        density_run(8192);
        density_run(12345);
        density_run(FS - 1);

        // R7 zero input holds output low
        do_reset();
        sample_in = '0;
        mism = 0;
        for (int i = 0; i < 1000; i++) begin
            if (bit_out) mism++;
            @(negedge clk);
        end
        check(mism == 0, "R7 zero input", mism, 0);

        // R8 full-scale input
        do_reset();
        sample_in = DW'(FS - 1);
        repeat (8) @(negedge clk);
        zeros = 0;
        for (int i = 0; i < 2 * FS; i++) begin
            if (!bit_out) zeros++;
            @(negedge clk);
        end
        check(zeros <= 2, "R8 full scale zeros", zeros, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule